// File: doc/BRIEF.md
# Dual-Section Phase/Frequency Detector with Lock Monitor

This block sits between the reference divider, the feedback divider and the charge pump of a two-section frequency synthesizer. Each section receives a reference strobe and a divided-feedback strobe, both as one-cycle pulses in the oscillator clock domain. It runs a three-state phase/frequency comparison whose drive sense can be reversed, so that either VCO slope can be used. Every comparison ends with a one-cycle pulse on both the up and the down lines. This pulse removes the dead zone around zero phase error.

A lock judge per section measures the width of each phase error in oscillator cycles. It drops lock as soon as an open error grows to the unlock width. It grants lock only after three comparisons in a row stay within the good width. A section held in power save stops driving the pump and counts as locked. On wake-up its detector starts from rest, and the first comparison has its one-sided drive clipped to a fixed number of cycles, which limits the VCO jump. One shared output pin carries either the AND of both sections' lock states or one of the four comparison inputs for monitoring. The current-select bit of each section passes straight through to the analog pump.

Top module: `dual_pfd_lock`

## Requirements
- R1: The drive sense follows the polarity input. With pol_i=1 a section drives high (drv_en_o=1, drv_lvl_o=1) while its reference leads and drives low (drv_en_o=1, drv_lvl_o=0) while its feedback leads. pol_i=0 swaps high and low. When neither line or both lines are active, drv_en_o=0, which is high impedance. up_o/dn_o show the post-polarity lines, and drv_lvl_o equals up_o.
- R2: For a reference strobe and a feedback strobe D cycles apart, the one-sided drive lasts exactly D cycles. It starts in the cycle after the leading strobe is sampled. Strobes in the same cycle give no one-sided drive.
- R3: Every completed comparison, including one with zero error, is followed by exactly one cycle with up_o and dn_o both high.
- R4: A second strobe from the leading side during an open comparison is ignored. The one-sided drive still lasts the full distance from the first leading strobe to the closing strobe.
- R5: A running section loses lock once an open error reaches 2 cycles.
- R6: A running section gains lock after 3 consecutive completed comparisons whose error is at most 1 cycle.
- R7: With run_i=0, a section stops driving in the following cycle and counts as locked. Its lock state is cleared, so after wake-up it reads unlocked until R6 is met again.
- R8: With mon_en_i=0, lock_mon_o is high one cycle after both sections are locked or in power save, and low otherwise.
- R9: With mon_en_i=1, lock_mon_o shows one cycle later the strobe selected by {mon_fb_i, mon_sect_i}: 00 = section 0 reference, 01 = section 1 reference, 10 = section 0 feedback, 11 = section 1 feedback.
- R10: In the first comparison after reset or wake-up, the one-sided drive is limited to 4 cycles. Later comparisons are not limited.
- R11: cur_o equals cur_i for each section.
- R12: During reset, no section drives (drv_en_o=0, up_o=dn_o=0) and lock_mon_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_i | input | 2 | Reference strobe per section |
| fb_i | input | 2 | Divided feedback strobe per section |
| run_i | input | 2 | Section active (0 = power save) |
| pol_i | input | 2 | Drive sense per section (1 = high when reference leads) |
| cur_i | input | 2 | Pump current select per section |
| mon_en_i | input | 1 | Shared pin carries a monitor strobe instead of lock |
| mon_sect_i | input | 1 | Monitor section select |
| mon_fb_i | input | 1 | Monitor feedback instead of reference |
| up_o | output | 2 | Post-polarity up line per section |
| dn_o | output | 2 | Post-polarity down line per section |
| drv_en_o | output | 2 | Pump output enabled (0 = high impedance) |
| drv_lvl_o | output | 2 | Pump output level when enabled |
| cur_o | output | 2 | Current select to the pump |
| lock_mon_o | output | 1 | Combined lock or monitor strobe |

## Verification
The bench measures drive widths for both leading sides under both polarities and at zero error. A swapped polarity would show up as high and low counts trading places, and a missing anti-dead-zone pulse would show up as a zero count of double-high cycles. It checks that lock does not appear after only two good comparisons and that a two-cycle error drops it. A section in power save must read as locked in the combined pin while the other section decides the result. It also covers a repeated leading strobe, which would lengthen the pulse wrongly, and the clipped first comparison after wake-up, which an unclipped design would let run the full error width. Finally it walks all four monitor selections.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    localparam int SECTIONS = 2;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LEAD  = 2'd1,
        PH_CLAMP = 2'd2,
        PH_BOTH  = 2'd3
    } phase_e;
endpackage

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
#(
    parameter int CNT_W    = 6,
    parameter int WAKE_MAX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             ref_i,
    input  logic             fb_i,
    output logic             up_o,
    output logic             dn_o,
    output logic             done_o,
    output logic [CNT_W-1:0] done_err_o,
    output logic             open_o,
    output logic [CNT_W-1:0] open_err_o
);
    localparam logic [CNT_W-1:0] WAKE_LIM = CNT_W'(WAKE_MAX);

    typedef struct packed {
        phase_e           ph;
        logic             lead_ref;
        logic             first;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic [CNT_W-1:0] err;
    } pfd_st_t;

    pfd_st_t s_d, s_q;
    logic closing;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        closing  = s_q.lead_ref ? fb_i : ref_i;
        cnt_inc  = (&s_q.cnt) ? s_q.cnt : s_q.cnt + 1'b1;
        if (!run_i) begin
            s_d.ph    = PH_IDLE;
            s_d.first = 1'b1;
            s_d.cnt   = '0;
        end else begin
            unique case (s_q.ph)
                PH_IDLE, PH_BOTH: begin
                    if (ref_i && fb_i) begin
                        s_d.ph    = PH_BOTH;
                        s_d.done  = 1'b1;
                        s_d.err   = '0;
                        s_d.cnt   = '0;
                        s_d.first = 1'b0;
                    end else if (ref_i || fb_i) begin
                        s_d.ph       = PH_LEAD;
                        s_d.lead_ref = ref_i;
                        s_d.cnt      = CNT_W'(1);
                    end else begin
                        s_d.ph = PH_IDLE;
                    end
                end
                PH_LEAD, PH_CLAMP: begin
                    if (closing) begin
                        s_d.ph    = PH_BOTH;
                        s_d.done  = 1'b1;
                        s_d.err   = s_q.cnt;
                        s_d.cnt   = '0;
                        s_d.first = 1'b0;
                    end else begin
                        s_d.cnt = cnt_inc;
                        if (s_q.ph == PH_LEAD && s_q.first && s_q.cnt >= WAKE_LIM)
                            s_d.ph = PH_CLAMP;
                    end
                end
                default: s_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ph       <= PH_IDLE;
            s_q.lead_ref <= 1'b0;
            s_q.first    <= 1'b1;
            s_q.cnt      <= '0;
            s_q.done     <= 1'b0;
            s_q.err      <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign up_o       = (s_q.ph == PH_BOTH) || (s_q.ph == PH_LEAD && s_q.lead_ref);
    assign dn_o       = (s_q.ph == PH_BOTH) || (s_q.ph == PH_LEAD && !s_q.lead_ref);
    assign done_o     = s_q.done;
    assign done_err_o = s_q.err;
    assign open_o     = (s_q.ph == PH_LEAD) || (s_q.ph == PH_CLAMP);
    assign open_err_o = s_q.cnt;

    // R7: a section in power save is quiet one cycle later
    assert_save_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!up_o && !dn_o));

    // R3: each finished comparison shows both lines high
    assert_end_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (up_o && dn_o));
endmodule

// File: rtl/lock_judge.sv
module lock_judge #(
    parameter int CNT_W    = 6,
    parameter int UNLOCK_W = 2,
    parameter int GOOD_W   = 1,
    parameter int CONFIRM  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             done_i,
    input  logic [CNT_W-1:0] err_i,
    input  logic             open_i,
    input  logic [CNT_W-1:0] open_err_i,
    output logic             sec_lock_o
);
    localparam int GW = $clog2(CONFIRM + 1);
    localparam logic [CNT_W-1:0] BAD_LIM  = CNT_W'(UNLOCK_W);
    localparam logic [CNT_W-1:0] GOOD_LIM = CNT_W'(GOOD_W);
    localparam logic [GW-1:0]    CONF_LIM = GW'(CONFIRM);

    typedef struct packed {
        logic          locked;
        logic [GW-1:0] good;
    } judge_st_t;

    judge_st_t j_d, j_q;

    always_comb begin
        j_d = j_q;
        if (!run_i) begin
            j_d.locked = 1'b0;
            j_d.good   = '0;
        end else if (open_i && open_err_i >= BAD_LIM) begin
            j_d.locked = 1'b0;
            j_d.good   = '0;
        end else if (done_i) begin
            if (err_i >= BAD_LIM) begin
                j_d.locked = 1'b0;
                j_d.good   = '0;
            end else if (err_i <= GOOD_LIM) begin
                if (j_q.good + 1'b1 >= CONF_LIM) j_d.locked = 1'b1;
                if (j_q.good != CONF_LIM) j_d.good = j_q.good + 1'b1;
            end else begin
                j_d.good = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            j_q.locked <= 1'b0;
            j_q.good   <= '0;
        end else begin
            j_q <= j_d;
        end
    end

    assign sec_lock_o = !run_i || j_q.locked;

    // R6: lock is only granted right after a good comparison
    assert_lock_on_good_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(j_q.locked) |-> ($past(done_i) && $past(err_i) <= GOOD_LIM));

    // R5: an open error at the unlock width clears lock
    assert_drop_on_wide_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && open_i && open_err_i >= BAD_LIM) |=> !j_q.locked);

    // R7: power save clears the stored lock state
    assert_save_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !j_q.locked);
endmodule

// File: rtl/mon_sel.sv
module mon_sel
    import pfd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SECTIONS-1:0] sec_lock_i,
    input  logic [SECTIONS-1:0] ref_i,
    input  logic [SECTIONS-1:0] fb_i,
    input  logic                mon_en_i,
    input  logic                mon_sect_i,
    input  logic                mon_fb_i,
    output logic                pin_o
);
    logic pin_d, pin_q;
    logic probe;

    always_comb begin
        probe = mon_fb_i ? fb_i[mon_sect_i] : ref_i[mon_sect_i];
        pin_d = mon_en_i ? probe : (&sec_lock_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

    assign pin_o = pin_q;
endmodule

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock
    import pfd_pkg::*;
#(
    parameter int CNT_W    = 6,
    parameter int UNLOCK_W = 2,
    parameter int GOOD_W   = 1,
    parameter int CONFIRM  = 3,
    parameter int WAKE_MAX = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SECTIONS-1:0] ref_i,
    input  logic [SECTIONS-1:0] fb_i,
    input  logic [SECTIONS-1:0] run_i,
    input  logic [SECTIONS-1:0] pol_i,
    input  logic [SECTIONS-1:0] cur_i,
    input  logic                mon_en_i,
    input  logic                mon_sect_i,
    input  logic                mon_fb_i,
    output logic [SECTIONS-1:0] up_o,
    output logic [SECTIONS-1:0] dn_o,
    output logic [SECTIONS-1:0] drv_en_o,
    output logic [SECTIONS-1:0] drv_lvl_o,
    output logic [SECTIONS-1:0] cur_o,
    output logic                lock_mon_o
);
    logic [SECTIONS-1:0] raw_up, raw_dn, done, open, sec_lock;
    logic [CNT_W-1:0]    done_err [SECTIONS];
    logic [CNT_W-1:0]    open_err [SECTIONS];

    for (genvar g = 0; g < SECTIONS; g++) begin : g_sec
        pfd_core #(.CNT_W(CNT_W), .WAKE_MAX(WAKE_MAX)) i_pfd (
            .clk        (clk),
            .rst_n      (rst_n),
            .run_i      (run_i[g]),
            .ref_i      (ref_i[g]),
            .fb_i       (fb_i[g]),
            .up_o       (raw_up[g]),
            .dn_o       (raw_dn[g]),
            .done_o     (done[g]),
            .done_err_o (done_err[g]),
            .open_o     (open[g]),
            .open_err_o (open_err[g])
        );

        lock_judge #(.CNT_W(CNT_W), .UNLOCK_W(UNLOCK_W), .GOOD_W(GOOD_W),
                     .CONFIRM(CONFIRM)) i_judge (
            .clk        (clk),
            .rst_n      (rst_n),
            .run_i      (run_i[g]),
            .done_i     (done[g]),
            .err_i      (done_err[g]),
            .open_i     (open[g]),
            .open_err_i (open_err[g]),
            .sec_lock_o (sec_lock[g])
        );

        assign up_o[g]      = pol_i[g] ? raw_up[g] : raw_dn[g];
        assign dn_o[g]      = pol_i[g] ? raw_dn[g] : raw_up[g];
        assign drv_en_o[g]  = up_o[g] ^ dn_o[g];
        assign drv_lvl_o[g] = up_o[g];
    end

    assign cur_o = cur_i;

    mon_sel i_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_lock_i (sec_lock),
        .ref_i      (ref_i),
        .fb_i       (fb_i),
        .mon_en_i   (mon_en_i),
        .mon_sect_i (mon_sect_i),
        .mon_fb_i   (mon_fb_i),
        .pin_o      (lock_mon_o)
    );

    // R8: both sections asleep reads as locked on the shared pin
    assert_all_asleep_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_en_i && run_i == '0) |=> lock_mon_o);
endmodule

// File: tb/test_dual_pfd_lock.sv
`timescale 1ns/1ps
module test_dual_pfd_lock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ref_r = '0, fb_r = '0, run_r = '0, pol_r = 2'b11, cur_r = '0;
    logic       mon_en = 1'b0, mon_sect = 1'b0, mon_fb = 1'b0;
    logic [1:0] up, dn, drv_en, drv_lvl, cur;
    logic       lock_mon;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dual_pfd_lock i_dual_pfd_lock (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_r), .fb_i(fb_r), .run_i(run_r),
        .pol_i(pol_r), .cur_i(cur_r), .mon_en_i(mon_en), .mon_sect_i(mon_sect),
        .mon_fb_i(mon_fb), .up_o(up), .dn_o(dn), .drv_en_o(drv_en),
        .drv_lvl_o(drv_lvl), .cur_o(cur), .lock_mon_o(lock_mon)
    );

    // columns: ref cycle, fb cycle, polarity, expected high, low, double-high cycles
    localparam int NV = 8;
    localparam int VEC [NV][6] = '{
        '{0, 3, 1, 3, 0, 1},
        '{0, 3, 0, 0, 3, 1},
        '{5, 0, 1, 0, 5, 1},
        '{5, 0, 0, 5, 0, 1},
        '{0, 0, 1, 0, 0, 1},
        '{2, 2, 0, 0, 0, 1},
        '{0, 1, 1, 1, 0, 1},
        '{0, 9, 1, 9, 0, 1}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one comparison on section s; xr is an extra reference cycle or -1
    task automatic cmp(input int s, input int rc, input int fc, input int xr,
                       output int hi, output int lo, output int bo);
        int last;
        hi = 0; lo = 0; bo = 0;
        last = (rc > fc) ? rc : fc;
        if (xr > last) last = xr;
        for (int c = 0; c <= last + 3; c++) begin
            ref_r[s] = (c == rc) || (c == xr);
            fb_r[s]  = (c == fc);
            tick();
            if (drv_en[s]) begin
                if (drv_lvl[s]) hi++;
                else lo++;
            end
            if (up[s] && dn[s]) bo++;
        end
        ref_r[s] = 1'b0;
        fb_r[s]  = 1'b0;
        tick();
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int hi, lo, bo;
        repeat (3) tick();
        chk("R12 reset drive", int'(drv_en), 0);
        chk("R12 reset lines", int'({up, dn}), 0);
        chk("R12 reset lock pin", int'(lock_mon), 0);
        rst_n = 1'b1;
        tick(); tick();
        chk("R7 both asleep read locked", int'(lock_mon), 1);

        cur_r = 2'b10;
        #1;
        chk("R11 current select", int'(cur), 2);
        cur_r = 2'b01;
        #1;
        chk("R11 current select", int'(cur), 1);

        // wake section 0, section 1 stays asleep
        run_r[0] = 1'b1;
        tick(); tick();
        chk("R7 woken section unlocked", int'(lock_mon), 0);
        cmp(0, 0, 1, -1, hi, lo, bo);
        cmp(0, 0, 1, -1, hi, lo, bo);
        chk("R6 two good not enough", int'(lock_mon), 0);
        cmp(0, 0, 1, -1, hi, lo, bo);
        chk("R6 three good lock", int'(lock_mon), 1);
        cmp(0, 0, 2, -1, hi, lo, bo);
        chk("R2 two-cycle width", hi, 2);
        chk("R5 wide error unlocks", int'(lock_mon), 0);
        for (int k = 0; k < 3; k++) cmp(0, 1, 0, -1, hi, lo, bo);
        chk("R6 relock fb leading", int'(lock_mon), 1);

        // wake section 1: AND of sections
        run_r[1] = 1'b1;
        tick(); tick();
        chk("R8 one section unlocked", int'(lock_mon), 0);
        for (int k = 0; k < 3; k++) cmp(1, 0, 0, -1, hi, lo, bo);
        chk("R8 both locked", int'(lock_mon), 1);

        // vector table on section 0
        for (int v = 0; v < NV; v++) begin
            pol_r[0] = VEC[v][2][0];
            cmp(0, VEC[v][0], VEC[v][1], -1, hi, lo, bo);
            chk($sformatf("R1 R2 high count v%0d", v), hi, VEC[v][3]);
            chk($sformatf("R1 R2 low count v%0d", v), lo, VEC[v][4]);
            chk($sformatf("R3 end pulse v%0d", v), bo, VEC[v][5]);
        end
        pol_r[0] = 1'b1;

        cmp(0, 0, 4, 2, hi, lo, bo);
        chk("R4 extra lead strobe ignored", hi, 4);
        chk("R4 single end pulse", bo, 1);

        // power save while a comparison is open
        ref_r[0] = 1'b1;
        tick();
        ref_r[0] = 1'b0;
        tick();
        chk("R1 open drive before save", int'(drv_en[0]), 1);
        run_r[0] = 1'b0;
        tick();
        chk("R7 save stops drive", int'(drv_en[0]), 0);
        tick(); tick();
        chk("R7 R8 asleep counts locked", int'(lock_mon), 1);

        // wake-up clipping
        run_r[0] = 1'b1;
        tick();
        cmp(0, 0, 7, -1, hi, lo, bo);
        chk("R10 first drive clipped", hi, 4);
        chk("R10 clipped end pulse", bo, 1);
        cmp(0, 0, 6, -1, hi, lo, bo);
        chk("R10 later drive full", hi, 6);
        chk("R5 lock after wide errors", int'(lock_mon), 0);

        // monitor selection
        mon_en = 1'b1;
        for (int sel = 0; sel < 4; sel++) begin
            mon_sect = sel[0];
            mon_fb   = sel[1];
            ref_r = '0; fb_r = '0;
            if (sel[1]) fb_r[sel[0]] = 1'b1;
            else        ref_r[sel[0]] = 1'b1;
            tick();
            chk($sformatf("R9 monitor select %0d high", sel), int'(lock_mon), 1);
            ref_r = '1; fb_r = '1;
            if (sel[1]) fb_r[sel[0]] = 1'b0;
            else        ref_r[sel[0]] = 1'b0;
            tick();
            chk($sformatf("R9 monitor select %0d low", sel), int'(lock_mon), 0);
        end
        ref_r = '0; fb_r = '0;
        tick();

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule